// File: doc/BRIEF.md
# Status register write-enable controller

This block sits behind the command decoder of a serial flash device and owns the volatile state that governs whether write-class commands may proceed. That state is the write enable latch, the busy flag, the suspend flag, the status-register protect and lock bits, and the one-time lock bits of the security registers. Each clock cycle it takes at most one decoded command code. One cycle later it answers with a registered accept or reject pulse, and the status bits have already moved to their new values.

The operations it starts, such as program, erase and status write, are not modelled here. The durations of those operations are represented by a done pulse from outside. A power-on event input returns the volatile bits to their power-up state and keeps the non-volatile ones. After the event, a hold-off counter blocks commands that could modify contents for `HOLD_CYC` cycles. The write-protect pin is an active-low level. It takes part only in the decision on status writes.

Top module: `status_wr_gate`

## Requirements
- R1: On rst_ni low, every status bit is 0. On a por_i cycle, wel_o, busy_o, sus_o and srl_o go to 0 while srp_o and lb_o keep their values. The command presented in a por_i cycle has no effect, and acc_o and rej_o are 0 in the cycle after it.
- R2: The command codes are 1 set-latch, 2 clear-latch, 3 page program, 4 quad program, 5 sector erase, 6 half-block erase, 7 block erase, 8 chip erase, 9 status write, 10 security erase, 11 security program, 12 suspend and 13 resume. For a known code, exactly one of acc_o and rej_o is 1 in the next cycle. For codes 0, 14 and 15, both are 0.
- R3: Set-latch is accepted when not busy and not held off, and it sets wel_o. Clear-latch is accepted when not busy, and it clears wel_o. Otherwise each is rejected.
- R4: After reset release or a por_i cycle, the next `HOLD_CYC` clock edges reject codes 1 and 3 to 11.
- R5: A code from 3 to 11 is rejected while wel_o=0, busy_o=1 or sus_o=1. A rejected command changes no status bit.
- R6: Acceptance of a code from 3 to 11 sets busy_o and clears wel_o at the same edge. done_i clears busy_o, and done_i has no effect while busy_o=0.
- R7: Status write also requires srl_o=0, and requires either srp_o=0 or wp_ni=1. When it is rejected, wel_o is unchanged.
- R8: An accepted status write loads srp_o from sr_wdata_i[0]. It sets srl_o if sr_wdata_i[1] is 1, and ORs sr_wdata_i[2+k] into lb_o[k].
- R9: Once srl_o is 1, it stays 1 until a por_i cycle, and every status write is rejected.
- R10: Security erase or program of the register at index sec_idx_i is rejected when lb_o[sec_idx_i]=1 or when sec_idx_i>=NUM_SEC. lb_o bits never return to 0 except on rst_ni.
- R11: Suspend is accepted only while busy with codes 3 to 8, and it clears busy_o and sets sus_o. Resume is accepted only while sus_o=1, and it clears sus_o and sets busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all state |
| por_i | input | 1 | Power-on event, clears volatile state |
| cmd_i | input | 4 | Decoded command code, 0 for none |
| sec_idx_i | input | IDX_W | Target security register index |
| sr_wdata_i | input | NUM_SEC+2 | Status write data: protect, lock, security lock bits |
| wp_ni | input | 1 | Write-protect pin, active low |
| done_i | input | 1 | Running operation finished |
| acc_o | output | 1 | Previous command accepted |
| rej_o | output | 1 | Previous command rejected |
| wel_o | output | 1 | Write enable latch |
| busy_o | output | 1 | Operation in progress |
| sus_o | output | 1 | Operation suspended |
| srp_o | output | 1 | Status-register protect bit |
| srl_o | output | 1 | Status-register lock bit |
| lb_o | output | NUM_SEC | Security register lock bits |

## Verification
The hardest states to reach are the ones that need a chain of prior acceptances. One is a status write rejected by the lock bit. Another is a security program that is refused by a lock bit, which must first have been set by an earlier status write. A third is suspension of a running erase, followed by a program attempt during the suspension. The stimulus builds each chain explicitly: set-latch, the enabling command, a done pulse, and then the attempt under test. A behavioural model of the rules is compared with every output on every cycle. A power-on event is issued while the lock is set, to show that the volatile bits drop, that the non-volatile bits survive, and that the hold-off window starts again.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  typedef enum logic [3:0] {
    CMD_NONE   = 4'd0,
    CMD_WREN   = 4'd1,
    CMD_WRDI   = 4'd2,
    CMD_PP     = 4'd3,
    CMD_QPP    = 4'd4,
    CMD_SE     = 4'd5,
    CMD_BE32   = 4'd6,
    CMD_BE64   = 4'd7,
    CMD_CE     = 4'd8,
    CMD_WRSR   = 4'd9,
    CMD_SECER  = 4'd10,
    CMD_SECPR  = 4'd11,
    CMD_SUSP   = 4'd12,
    CMD_RESUME = 4'd13
  } sr_cmd_e;

  typedef struct packed {
    logic wel;
    logic busy;
    logic sus;
    logic arr;
    logic srp;
    logic srl;
  } sr_flags_t;

  function automatic logic is_array_op(logic [3:0] c);
    return (c >= 4'd3) && (c <= 4'd8);
  endfunction
endpackage

// File: rtl/sr_holdoff.sv
module sr_holdoff #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  output logic hold_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 2);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= LOAD;
    else if (por_i)            cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/sr_decide.sv
module sr_decide
  import sr_gate_pkg::*;
#(
  parameter int NUM_SEC = 3,
  parameter int IDX_W   = 2
) (
  input  logic [3:0]         cmd_i,
  input  logic               hold_i,
  input  logic               wp_ni,
  input  logic [IDX_W-1:0]   sec_idx_i,
  input  sr_flags_t          flags_i,
  input  logic [NUM_SEC-1:0] lb_i,
  output logic               acc_o,
  output logic               rej_o,
  output logic               start_o,
  output logic               wrsr_o,
  output logic               wren_o,
  output logic               wrdi_o,
  output logic               susp_o,
  output logic               resume_o
);
  logic known, ok, gate, lb_hit;

  // out-of-range index reads as locked
  always_comb begin
    lb_hit = 1'b1;
    for (int i = 0; i < NUM_SEC; i++)
      if (sec_idx_i == IDX_W'(i)) lb_hit = lb_i[i];
  end

  assign gate = flags_i.wel && !flags_i.busy && !flags_i.sus && !hold_i;

  always_comb begin
    known = 1'b1;
    ok    = 1'b0;
    unique case (cmd_i)
      CMD_WREN:                  ok = !flags_i.busy && !hold_i;
      CMD_WRDI:                  ok = !flags_i.busy;
      CMD_PP, CMD_QPP, CMD_SE,
      CMD_BE32, CMD_BE64, CMD_CE: ok = gate;
      CMD_WRSR:                  ok = gate && !flags_i.srl && (!flags_i.srp || wp_ni);
      CMD_SECER, CMD_SECPR:      ok = gate && !lb_hit;
      CMD_SUSP:                  ok = flags_i.busy && flags_i.arr;
      CMD_RESUME:                ok = flags_i.sus && !flags_i.busy;
      default:                   known = 1'b0;
    endcase
  end

  assign acc_o    = known && ok;
  assign rej_o    = known && !ok;
  assign start_o  = acc_o && (cmd_i >= 4'd3) && (cmd_i <= 4'd11);
  assign wrsr_o   = acc_o && (cmd_i == CMD_WRSR);
  assign wren_o   = acc_o && (cmd_i == CMD_WREN);
  assign wrdi_o   = acc_o && (cmd_i == CMD_WRDI);
  assign susp_o   = acc_o && (cmd_i == CMD_SUSP);
  assign resume_o = acc_o && (cmd_i == CMD_RESUME);
endmodule

// File: rtl/status_wr_gate.sv
module status_wr_gate
  import sr_gate_pkg::*;
#(
  parameter int NUM_SEC  = 3,
  parameter int HOLD_CYC = 16,
  localparam int IDX_W   = $clog2(NUM_SEC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_i,
  input  logic [3:0]         cmd_i,
  input  logic [IDX_W-1:0]   sec_idx_i,
  input  logic [NUM_SEC+1:0] sr_wdata_i,
  input  logic               wp_ni,
  input  logic               done_i,
  output logic               acc_o,
  output logic               rej_o,
  output logic               wel_o,
  output logic               busy_o,
  output logic               sus_o,
  output logic               srp_o,
  output logic               srl_o,
  output logic [NUM_SEC-1:0] lb_o
);
  sr_flags_t          flags_q;
  logic [NUM_SEC-1:0] lb_q;
  logic               acc_q, rej_q;
  logic               hold;
  logic acc, rej, start, wrsr, wren, wrdi, susp, resume;

  sr_holdoff #(.HOLD_CYC(HOLD_CYC)) i_holdoff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .por_i  (por_i),
    .hold_o (hold)
  );

  sr_decide #(.NUM_SEC(NUM_SEC), .IDX_W(IDX_W)) i_decide (
    .cmd_i     (cmd_i),
    .hold_i    (hold),
    .wp_ni     (wp_ni),
    .sec_idx_i (sec_idx_i),
    .flags_i   (flags_q),
    .lb_i      (lb_q),
    .acc_o     (acc),
    .rej_o     (rej),
    .start_o   (start),
    .wrsr_o    (wrsr),
    .wren_o    (wren),
    .wrdi_o    (wrdi),
    .susp_o    (susp),
    .resume_o  (resume)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      lb_q    <= '0;
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else if (por_i) begin
      flags_q.wel  <= 1'b0;
      flags_q.busy <= 1'b0;
      flags_q.sus  <= 1'b0;
      flags_q.arr  <= 1'b0;
      flags_q.srl  <= 1'b0;
      acc_q        <= 1'b0;
      rej_q        <= 1'b0;
    end else begin
      acc_q <= acc;
      rej_q <= rej;
      if (wren)               flags_q.wel <= 1'b1;
      else if (wrdi || start) flags_q.wel <= 1'b0;
      if (start) begin
        flags_q.busy <= 1'b1;
        flags_q.arr  <= is_array_op(cmd_i);
      end else if (resume) begin
        flags_q.busy <= 1'b1;
        flags_q.sus  <= 1'b0;
      end else if (susp) begin
        flags_q.busy <= 1'b0;
        flags_q.sus  <= 1'b1;
      end else if (done_i) begin
        flags_q.busy <= 1'b0;
      end
      if (wrsr) begin
        flags_q.srp <= sr_wdata_i[0];
        flags_q.srl <= flags_q.srl | sr_wdata_i[1];
        lb_q        <= lb_q | sr_wdata_i[2 +: NUM_SEC];
      end
    end
  end

  assign acc_o  = acc_q;
  assign rej_o  = rej_q;
  assign wel_o  = flags_q.wel;
  assign busy_o = flags_q.busy;
  assign sus_o  = flags_q.sus;
  assign srp_o  = flags_q.srp;
  assign srl_o  = flags_q.srl;
  assign lb_o   = lb_q;
endmodule

// File: rtl/sr_gate_chk.sv
module sr_gate_chk #(
  parameter int NUM_SEC = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               por_i,
  input logic [3:0]         cmd_i,
  input logic               acc_o,
  input logic               rej_o,
  input logic               wel_o,
  input logic               busy_o,
  input logic               sus_o,
  input logic               srl_o,
  input logic [NUM_SEC-1:0] lb_o
);
  // R2
  acc_rej_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_o && rej_o));

  // R3
  wel_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> ($past(cmd_i) == 4'd1));

  // R7
  wrsr_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && $past(cmd_i) == 4'd9) |-> $past(wel_o));

  // R9
  srl_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(srl_o) && !$past(por_i)) |-> srl_o);

  // R9
  wrsr_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && $past(cmd_i) == 4'd9) |-> !$past(srl_o));

  // R10
  lb_no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_o & $past(lb_o)) == $past(lb_o));

  // R11
  busy_sus_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && sus_o));
endmodule

bind status_wr_gate sr_gate_chk #(.NUM_SEC(NUM_SEC)) i_sr_gate_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .por_i  (por_i),
  .cmd_i  (cmd_i),
  .acc_o  (acc_o),
  .rej_o  (rej_o),
  .wel_o  (wel_o),
  .busy_o (busy_o),
  .sus_o  (sus_o),
  .srl_o  (srl_o),
  .lb_o   (lb_o)
);

// File: tb/test_status_wr_gate.sv
module test_status_wr_gate;
  localparam int NSEC = 3;
  localparam int HOLD = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            por = 1'b0;
  logic [3:0]      cmd = 4'd0;
  logic [1:0]      idx = 2'd0;
  logic [NSEC+1:0] wd = '0;
  logic            wp_n = 1'b1;
  logic            done = 1'b0;
  logic acc, rej, wel, busy, sus, srp, srl;
  logic [NSEC-1:0] lb;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  bit m_wel, m_busy, m_sus, m_arr, m_srp, m_srl, m_acc, m_rej;
  bit [NSEC-1:0] m_lb;
  int m_cnt = HOLD;

  always #5 clk = ~clk;

  status_wr_gate #(.NUM_SEC(NSEC), .HOLD_CYC(HOLD)) i_status_wr_gate (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .cmd_i(cmd), .sec_idx_i(idx),
    .sr_wdata_i(wd), .wp_ni(wp_n), .done_i(done), .acc_o(acc), .rej_o(rej),
    .wel_o(wel), .busy_o(busy), .sus_o(sus), .srp_o(srp), .srl_o(srl), .lb_o(lb)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    bit hold, ok, known, g;
    if (!rst_n) begin
      {m_wel, m_busy, m_sus, m_arr, m_srp, m_srl, m_acc, m_rej} = '0;
      m_lb = '0; m_cnt = HOLD;
    end else if (por) begin
      {m_wel, m_busy, m_sus, m_arr, m_srl, m_acc, m_rej} = '0;
      m_cnt = HOLD;
    end else begin
      hold = (m_cnt != 0);
      if (m_cnt != 0) m_cnt--;
      g = m_wel && !m_busy && !m_sus && !hold;
      known = 1; ok = 0;
      if (cmd == 1) ok = !m_busy && !hold;
      else if (cmd == 2) ok = !m_busy;
      else if (cmd >= 3 && cmd <= 8) ok = g;
      else if (cmd == 9) ok = g && !m_srl && (!m_srp || wp_n);
      else if (cmd == 10 || cmd == 11) ok = g && (idx < NSEC) && !m_lb[idx];
      else if (cmd == 12) ok = m_busy && m_arr;
      else if (cmd == 13) ok = m_sus && !m_busy;
      else known = 0;
      m_acc = known && ok;
      m_rej = known && !ok;
      if (m_acc) begin
        if (cmd == 1) m_wel = 1;
        else if (cmd == 2) m_wel = 0;
        else if (cmd <= 11) begin
          m_wel = 0; m_busy = 1; m_arr = (cmd <= 8);
          if (cmd == 9) begin
            m_srp = wd[0];
            m_srl = m_srl | wd[1];
            m_lb  = m_lb | wd[NSEC+1:2];
          end
        end else if (cmd == 12) begin m_busy = 0; m_sus = 1; end
        else begin m_sus = 0; m_busy = 1; end
      end else if (done) m_busy = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "acc", acc, m_acc);
    chk(cur_req, "rej", rej, m_rej);
    chk(cur_req, "wel", wel, m_wel);
    chk(cur_req, "busy", busy, m_busy);
    chk(cur_req, "sus", sus, m_sus);
    chk(cur_req, "srp", srp, m_srp);
    chk(cur_req, "srl", srl, m_srl);
    chk(cur_req, "lb", lb, m_lb);
  end

  task automatic cyc(int c, int ix = 0, int w = 0, bit d = 0);
    cmd = 4'(c); idx = 2'(ix); wd = (NSEC+2)'(w); done = d;
    @(negedge clk);
    cmd = 4'd0; done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "wel_rst", wel, 0);
    chk("R1", "lb_rst", lb, 0);
    rst_n = 1'b1;

    cur_req = "R4";
    for (int i = 0; i < HOLD + 1; i++) begin
      cyc(1);
      chk("R4", "rej_hold", rej, (i < HOLD) ? 1 : 0);
    end
    chk("R3", "wel_set", wel, 1);

    cur_req = "R3";
    cyc(2); chk("R3", "wel_clr", wel, 0);
    cur_req = "R5";
    cyc(3); chk("R5", "rej_nowel", rej, 1); chk("R5", "busy_nowel", busy, 0);

    cur_req = "R6";
    cyc(1); cyc(3);
    chk("R6", "busy_pp", busy, 1); chk("R6", "wel_pp", wel, 0);
    cyc(1); chk("R3", "rej_wren_busy", rej, 1);
    cyc(5); chk("R5", "rej_busy", rej, 1);
    cyc(0, 0, 0, 1); chk("R6", "busy_done", busy, 0);
    cyc(0, 0, 0, 1); chk("R6", "busy_idle_done", busy, 0);

    cur_req = "R11";
    cyc(1); cyc(5); cyc(12);
    chk("R11", "sus_set", sus, 1); chk("R11", "busy_susp", busy, 0);
    cyc(1); chk("R3", "wel_in_sus", wel, 1);
    cyc(3); chk("R5", "rej_sus", rej, 1); chk("R5", "wel_kept", wel, 1);
    cyc(13); chk("R11", "busy_resume", busy, 1); chk("R11", "sus_resume", sus, 0);
    cyc(0, 0, 0, 1);
    cyc(12); chk("R11", "rej_susp_idle", rej, 1);
    cyc(13); chk("R11", "rej_resume_idle", rej, 1);
    cyc(9, 0, 0); cyc(12); chk("R11", "rej_susp_wrsr", rej, 1);
    cyc(0, 0, 0, 1);

    cur_req = "R7";
    wp_n = 1'b0;
    cyc(1); cyc(9, 0, 1); chk("R8", "srp_set", srp, 1);
    cyc(0, 0, 0, 1);
    cyc(1); cyc(9, 0, 1); chk("R7", "rej_wp", rej, 1); chk("R7", "wel_after_rej", wel, 1);
    wp_n = 1'b1;
    cyc(9, 0, 1); chk("R7", "acc_wp_hi", acc, 1);
    cyc(0, 0, 0, 1);

    cur_req = "R10";
    cyc(1); cyc(11, 1); chk("R10", "acc_secpr", acc, 1);
    cyc(0, 0, 0, 1);
    cyc(1); cyc(9, 0, 9); chk("R8", "lb_set", lb, 2);
    cyc(0, 0, 0, 1);
    cyc(1); cyc(11, 1); chk("R10", "rej_locked", rej, 1);
    cyc(10, 0); chk("R10", "acc_unlocked", acc, 1);
    cyc(0, 0, 0, 1);
    cyc(1); cyc(10, 3); chk("R10", "rej_range", rej, 1);
    cyc(9, 0, 1); chk("R10", "lb_kept", lb, 2);
    cyc(0, 0, 0, 1);

    cur_req = "R9";
    cyc(1); cyc(9, 0, 3); chk("R9", "srl_set", srl, 1);
    cyc(0, 0, 0, 1);
    cyc(1); cyc(9, 0, 0); chk("R9", "rej_srl", rej, 1);
    cyc(0); chk("R9", "srl_hold", srl, 1);

    cur_req = "R1";
    por = 1'b1; cyc(1); por = 1'b0;
    chk("R1", "srl_por", srl, 0); chk("R1", "wel_por", wel, 0);
    chk("R1", "srp_por", srp, 1); chk("R1", "lb_por", lb, 2);
    chk("R1", "acc_por", acc, 0);
    cur_req = "R4";
    cyc(1); chk("R4", "rej_por_hold", rej, 1);
    repeat (HOLD) cyc(0);
    cyc(1); cyc(9, 0, 1); chk("R9", "acc_after_por", acc, 1);
    cyc(0, 0, 0, 1);

    cur_req = "R2";
    cyc(14); chk("R2", "none14", acc + rej, 0);
    cyc(15); chk("R2", "none15", acc + rej, 0);
    cyc(0);  chk("R2", "none0", acc + rej, 0);

    cur_req = "R1";
    rst_n = 1'b0; @(negedge clk);
    chk("R1", "srp_rst", srp, 0); chk("R1", "lb_rst2", lb, 0);
    rst_n = 1'b1; cyc(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule